// File: doc/BRIEF.md
# Graphic LCD Column Driver Host Port and Command Decoder

This block is the host-facing side of a column driver for a dot-matrix LCD. A microcontroller reaches it over an 8-bit parallel bus. The bus carries a strobe, a data/command select, a read/write select and three chip selects. The block brings those pins into its own clock domain and treats the falling strobe edge as the end of an access. It decodes display-control commands and keeps a page register and a column counter. Data bytes go to and come from a 512-byte display memory, and a status byte can be read back at any time.

Data reads are pipelined through an output latch. Each data read returns the byte that the previous access latched, then reloads the latch from the current address. After an address change the host therefore performs one dummy read. Every data access advances the column counter. After each accepted access a short busy window follows, and accesses that arrive during it are dropped. The display on/off bit and the start-line value are exported for the refresh logic.

Top module: `glcd_host_if`

## Requirements
- R1: An access takes effect only when cs_a_n=0, cs_b_n=0 and cs_c=1 while the strobe is high. An unselected access changes no display bit, start line, page, column or memory byte, and the bus is not driven.
- R2: Writes (rd_nwr=0) take bus_in at the falling edge of en_stb. During a selected read (rd_nwr=1), bus_oe is 1 while en_stb is high, and it is 0 at all other times.
- R3: Command writes (sel_data=0, rd_nwr=0) decode as follows. 0x3E turns the display off and 0x3F turns it on. 01cccccc loads column c. 10111ppp loads page p. 11ssssss loads start line s.
- R4: Any other command byte (for example 0x00, 0x80 or 0x3C) changes no display bit, start line, page or column.
- R5: A status read (sel_data=0, rd_nwr=1) returns bit 7 = busy, bit 5 = display off, bit 4 = reset active, with all other bits 0. It needs no dummy read and alters nothing.
- R6: A data read returns the current output latch. The latch is then reloaded from memory at {page, column} as it stood before the increment, so the first read after an address change returns stale data.
- R7: Every accepted data write or data read adds 1 to the 6-bit column, and the column wraps from 63 to 0. The page never changes on its own.
- R8: A data write stores the byte at memory address {page[2:0], column[5:0]}. Different pages hold independent bytes at the same column.
- R9: While rst_n is low the display is off, the start line is 0, and status reads return 0x30. Every other access is ignored, including after rst_n is released.
- R10: Each accepted command or data access keeps busy high for BUSY_CYC clocks (default 2). An access whose strobe falls inside that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset; also reported in status |
| en_stb | input | 1 | Bus strobe; an access ends at its falling edge |
| sel_data | input | 1 | 1 = display memory data, 0 = command or status |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| bus_in | input | 8 | Byte driven by the host |
| bus_out | output | 8 | Byte returned to the host (status or output latch) |
| bus_oe | output | 1 | Drive enable for bus_out; 0 means high impedance |
| disp_on | output | 1 | Display enable for the refresh path |
| start_line | output | 6 | Display start line for the refresh path |

## Verification
Two of the block's functions can fall in the same cycle. One is the busy window opened by an accepted access. The other is the strobe edge of a following access. The bench sends a write and then a second write whose strobe falls two clocks later, which is still inside the window. A readback showing the first byte at the column and the next accepted byte in the following column shows that the second write was dropped without stepping the column. The bench also issues a status read right behind a write and expects bit 7 to be set, and then clear once the window has closed.

// File: rtl/glcd_host_pkg.sv
// Shared types and helpers for the LCD host port.
// Assumes an 8-bit command byte; field positions below are behaviour.
package glcd_host_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ONOFF,
        OP_COL,
        OP_PAGE,
        OP_START
    } glcd_op_t;

    // Classify a command byte by its fixed prefix bits.
    function automatic glcd_op_t decode_op(input logic [7:0] b);
        if (b[7:1] == 7'b0011111)    return OP_ONOFF;
        else if (b[7:6] == 2'b01)    return OP_COL;
        else if (b[7:3] == 5'b10111) return OP_PAGE;
        else if (b[7:6] == 2'b11)    return OP_START;
        else                         return OP_NONE;
    endfunction

endpackage

// File: rtl/glcd_bus_sync.sv
// Brings the asynchronous host pins into clk and flags the strobe fall.
// Assumes the strobe is the MSB of d and that the other fields are steady
// while the strobe is high; held carries the last sample taken with it high.
module glcd_bus_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic         strb,
    output logic [W-2:0] held
);

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    // Shift the pin vector through the synchronizer chain and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign strb = prev[W-1] & ~stg[STAGES-1][W-1];
    assign held = prev[W-2:0];

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> !strb);

endmodule

// File: rtl/glcd_dram.sv
// Single-port synchronous display memory, one registered read per clock.
// Assumes a write and a read never target the same cycle's data for reuse.
module glcd_dram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write on request and register the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        q <= mem[addr];
    end

endmodule

// File: rtl/glcd_cmd_core.sv
// Command decoder, address state, busy window and output latch.
// Assumes strb is a one-cycle pulse with its fields valid in the same cycle.
module glcd_cmd_core
    import glcd_host_pkg::*;
#(
    parameter int DW       = 8,
    parameter int PW       = 3,
    parameter int CW       = 6,
    parameter int BUSY_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strb,
    input  logic            f_sel,
    input  logic            f_data,
    input  logic            f_rd,
    input  logic [DW-1:0]   f_byte,
    output logic            ram_we,
    output logic [PW+CW-1:0] ram_addr,
    output logic [DW-1:0]   ram_wdata,
    input  logic [DW-1:0]   ram_q,
    output logic [DW-1:0]   out_byte,
    output logic            busy,
    output logic            disp_on,
    output logic [CW-1:0]   start_line
);

    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [PW-1:0] page;
    logic [CW-1:0] col;
    logic [BW-1:0] busy_cnt;
    logic          rd_pend;
    logic          take;
    logic          is_stat;
    glcd_op_t      op;

    assign is_stat   = ~f_data & f_rd;
    assign take      = strb & f_sel & ~busy & ~is_stat;
    assign op        = decode_op(f_byte[7:0]);
    assign busy      = (busy_cnt != '0);
    assign ram_we    = take & f_data & ~f_rd;
    assign ram_addr  = {page, col};
    assign ram_wdata = f_byte;

    // Open the busy window on acceptance and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (take)  busy_cnt <= BW'(BUSY_CYC);
        else if (busy)  busy_cnt <= busy_cnt - 1'b1;
    end

    // Apply accepted commands and data accesses to the address and display state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page       <= '0;
            col        <= '0;
            disp_on    <= 1'b0;
            start_line <= '0;
            rd_pend    <= 1'b0;
            out_byte   <= '0;
        end else begin
            rd_pend <= take & f_data & f_rd;
            if (rd_pend) out_byte <= ram_q;
            if (take) begin
                if (f_data) begin
                    col <= col + 1'b1;
                end else begin
                    case (op)
                        OP_ONOFF: disp_on    <= f_byte[0];
                        OP_COL:   col        <= f_byte[CW-1:0];
                        OP_PAGE:  page       <= f_byte[PW-1:0];
                        OP_START: start_line <= f_byte[CW-1:0];
                        default:  ;
                    endcase
                end
            end
        end
    end

    assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && f_data) |=> (col == CW'($past(col) + 1'b1)));

    assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && f_data) |=> $stable(page));

    assert_busy_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(page) && $stable(col) && $stable(disp_on) && $stable(start_line)));

    assert_busy_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

    assert_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !f_sel && !busy) |=> ($stable(page) && $stable(col) && $stable(disp_on)
                                       && $stable(start_line) && !busy));

    always_comb begin
        assert_busy_len_R10: assert (busy_cnt <= BW'(BUSY_CYC));
    end

endmodule

// File: rtl/glcd_host_if.sv
// Top of the LCD host port: pin synchronizer, command core and display memory.
// Assumes the status byte and read drive follow the raw pins combinationally.
module glcd_host_if #(
    parameter int DW          = 8,
    parameter int PW          = 3,
    parameter int CW          = 6,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_stb,
    input  logic          sel_data,
    input  logic          rd_nwr,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    input  logic          cs_c,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          disp_on,
    output logic [CW-1:0] start_line
);

    localparam int SW = DW + 4;
    localparam int AW = PW + CW;

    logic          sel_raw;
    logic          strb;
    logic [SW-2:0] held;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_q;
    logic [DW-1:0] out_byte;
    logic          busy;
    logic [DW-1:0] status;

    assign sel_raw = ~cs_a_n & ~cs_b_n & cs_c;
    assign status  = {busy, 1'b0, ~disp_on, ~rst_n, {(DW-4){1'b0}}};
    assign bus_oe  = sel_raw & rd_nwr & en_stb;
    assign bus_out = sel_data ? out_byte : status;

    glcd_bus_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({en_stb, sel_raw, sel_data, rd_nwr, bus_in}),
        .strb  (strb),
        .held  (held)
    );

    glcd_cmd_core #(.DW(DW), .PW(PW), .CW(CW), .BUSY_CYC(BUSY_CYC)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb       (strb),
        .f_sel      (held[DW+2]),
        .f_data     (held[DW+1]),
        .f_rd       (held[DW]),
        .f_byte     (held[DW-1:0]),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_q      (ram_q),
        .out_byte   (out_byte),
        .busy       (busy),
        .disp_on    (disp_on),
        .start_line (start_line)
    );

    glcd_dram #(.AW(AW), .DW(DW)) i_dram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

endmodule

// File: tb/test_glcd_host_if.sv
module test_glcd_host_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_stb = 1'b0;
    logic       sel_data = 1'b0;
    logic       rd_nwr = 1'b0;
    logic       cs_a_n = 1'b0;
    logic       cs_b_n = 1'b0;
    logic       cs_c = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       disp_on;
    logic [5:0] start_line;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] rv;
    logic       roe;

    always #10 clk = ~clk;

    glcd_host_if i_glcd_host_if (
        .clk(clk), .rst_n(rst_n), .en_stb(en_stb), .sel_data(sel_data),
        .rd_nwr(rd_nwr), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .disp_on(disp_on), .start_line(start_line)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        cs_a_n = 1'b0; cs_b_n = 1'b0; cs_c = 1'b1;
    endtask

    task automatic bus_wr(input logic ds, input logic [7:0] b, input int hi, input int gap);
        @(negedge clk);
        sel_data = ds; rd_nwr = 1'b0; bus_in = b; en_stb = 1'b1;
        repeat (hi) @(negedge clk);
        en_stb = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic bus_rd(input logic ds, output logic [7:0] v, output logic oe);
        @(negedge clk);
        sel_data = ds; rd_nwr = 1'b1; en_stb = 1'b1;
        repeat (2) @(negedge clk);
        v = bus_out; oe = bus_oe;
        en_stb = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        bus_wr(1'b0, b, 2, 8);
    endtask

    task automatic dwr(input logic [7:0] b);
        bus_wr(1'b1, b, 2, 8);
    endtask

    task automatic t_reset_state();
        chk("R9 disp_on in reset", {7'b0, disp_on}, 8'h00);
        chk("R9 start_line in reset", {2'b0, start_line}, 8'h00);
        bus_rd(1'b0, rv, roe);
        chk("R5 R9 status in reset", rv, 8'h30);
        chk("R2 oe on status read", {7'b0, roe}, 8'h01);
    endtask

    task automatic t_instr();
        cmd(8'h3F);
        chk("R3 display on", {7'b0, disp_on}, 8'h01);
        bus_rd(1'b0, rv, roe);
        chk("R5 status ready and on", rv, 8'h00);
        cmd(8'hC0 | 8'd37);
        chk("R3 start line", {2'b0, start_line}, 8'd37);
        cmd(8'h3E);
        chk("R3 display off", {7'b0, disp_on}, 8'h00);
        bus_rd(1'b0, rv, roe);
        chk("R5 status off", rv, 8'h20);
    endtask

    task automatic t_unknown();
        cmd(8'hB9); cmd(8'h45); dwr(8'h11);
        cmd(8'hB9); cmd(8'h45);
        cmd(8'h00); cmd(8'h80); cmd(8'h3C);
        dwr(8'h5A);
        chk("R4 disp_on untouched", {7'b0, disp_on}, 8'h00);
        chk("R4 start line untouched", {2'b0, start_line}, 8'd37);
        cmd(8'hB9); cmd(8'h45);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R4 page and column untouched", rv, 8'h5A);
    endtask

    task automatic t_write_read();
        cmd(8'hBA); cmd(8'h4A); dwr(8'hA1); dwr(8'hB2);
        cmd(8'hBB); cmd(8'h4A); dwr(8'hC3);
        cmd(8'hBA); cmd(8'h4A);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R6 R8 read after dummy", rv, 8'hA1);
        chk("R2 oe on data read", {7'b0, roe}, 8'h01);
        cmd(8'h4A);
        bus_rd(1'b1, rv, roe);
        chk("R6 stale latch after address change", rv, 8'hB2);
        bus_rd(1'b1, rv, roe);
        chk("R6 fresh after stale", rv, 8'hA1);
        cmd(8'hBB); cmd(8'h4A);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R8 page separation", rv, 8'hC3);
    endtask

    task automatic t_wrap();
        cmd(8'hBC); cmd(8'h7F); dwr(8'h77); dwr(8'h88);
        cmd(8'h40);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R7 write wrap to column 0", rv, 8'h88);
        cmd(8'h7F);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R7 column 63", rv, 8'h77);
        bus_rd(1'b1, rv, roe);
        chk("R7 read wrap keeps page", rv, 8'h88);
    endtask

    task automatic t_chipsel();
        cs_a_n = 1'b1; cmd(8'h3F); sel_on();
        chk("R1 cs_a_n high ignored", {7'b0, disp_on}, 8'h00);
        cs_b_n = 1'b1; cmd(8'h3F); sel_on();
        chk("R1 cs_b_n high ignored", {7'b0, disp_on}, 8'h00);
        cs_c = 1'b0; cmd(8'h3F); sel_on();
        chk("R1 cs_c low ignored", {7'b0, disp_on}, 8'h00);
        cmd(8'hBC); cmd(8'h41); dwr(8'h99);
        cs_c = 1'b0; dwr(8'h55);
        bus_rd(1'b1, rv, roe);
        chk("R1 R2 no drive when unselected", {7'b0, roe}, 8'h00);
        sel_on();
        dwr(8'h66);
        cmd(8'h41);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R1 first byte", rv, 8'h99);
        bus_rd(1'b1, rv, roe);
        chk("R1 column not stepped by unselected access", rv, 8'h66);
    endtask

    task automatic t_busy();
        cmd(8'hBD); cmd(8'h40);
        bus_wr(1'b1, 8'h12, 2, 0);
        bus_rd(1'b0, rv, roe);
        chk("R10 busy bit during window", rv & 8'h80, 8'h80);
        bus_rd(1'b0, rv, roe);
        chk("R10 busy bit clears", rv & 8'h80, 8'h00);
        bus_wr(1'b1, 8'h21, 2, 0);
        bus_wr(1'b1, 8'h34, 1, 8);
        dwr(8'h56);
        cmd(8'h40);
        bus_rd(1'b1, rv, roe);
        bus_rd(1'b1, rv, roe);
        chk("R10 first byte kept", rv, 8'h12);
        bus_rd(1'b1, rv, roe);
        chk("R10 accepted write before window", rv, 8'h21);
        bus_rd(1'b1, rv, roe);
        chk("R10 write inside window dropped", rv, 8'h56);
    endtask

    task automatic t_reset_mid();
        cmd(8'h3F); cmd(8'hC9);
        chk("R3 start line 9", {2'b0, start_line}, 8'd9);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 display forced off", {7'b0, disp_on}, 8'h00);
        chk("R9 start line cleared", {2'b0, start_line}, 8'h00);
        bus_rd(1'b0, rv, roe);
        chk("R9 status during reset", rv, 8'h30);
        cmd(8'h3F); cmd(8'hC5);
        @(negedge clk); rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 command during reset ignored", {7'b0, disp_on}, 8'h00);
        chk("R9 start line stays 0", {2'b0, start_line}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_instr();
        t_unknown();
        t_write_read();
        t_wrap();
        t_chipsel();
        t_busy();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule